// File: doc/BRIEF.md
# Chip-Select Timed Power Mode Controller

This block holds the power state of a dual-channel sampling serial converter and updates it from nothing more than the timing of its chip-select line. Each time chip-select (active low) falls, a frame begins and the block counts serial-clock falling edges. When chip-select rises again, the number of edges counted so far picks what happens next. The same count has a different meaning depending on the mode the block is in when the frame starts.

Both raw inputs come from outside the system-clock domain. Each passes through its own multi-stage synchroniser, and edges are detected after it. The one time base besides the edge count is a power-up delay counter on the system clock. It is loaded with one of two parameterised lengths, a shorter one for waking from partial power-down and a longer one for waking from full power-down. The outputs are the mode, a one-cycle "conversion valid" pulse, a one-cycle "conversion aborted" pulse, and a "powering up" level.

Top module: `pmc_top`

## Requirements
- R1: `mode` is encoded as 0 = normal, 1 = partial power-down, 2 = full power-down, and it never takes the value 3. After reset the mode is normal, `powering` is low and there are no pulses.
- R2: A frame runs from a chip-select fall to the next chip-select rise. The edge count restarts at zero on every chip-select fall and counts only serial-clock falling edges seen while chip-select is low. The decision uses the count held when chip-select rises.
- R3: In normal mode, a frame with fewer than 2 edges leaves the mode normal and produces neither pulse.
- R4: In normal mode, a frame with at least 2 and fewer than 10 edges moves the block to partial power-down and gives one `convAbort` pulse.
- R5: In normal mode, a frame with at least 10 and fewer than 14 edges keeps the mode normal and gives one `convAbort` pulse.
- R6: A frame that starts in normal mode while no power-up is running, and that has 14 or more edges, gives one `convValid` pulse when chip-select rises.
- R7: In partial power-down, a frame with fewer than 2 edges leaves the mode at partial power-down.
- R8: In either power-down mode, the 10th edge of a frame raises `powering` for the partial power-up delay (from partial). When the delay ends, the mode becomes normal. That wake-up frame gives no `convValid`, and the next full frame does.
- R9: In partial power-down, a frame with at least 2 and fewer than 10 edges moves the block to full power-down. In full power-down, any frame with fewer than 10 edges leaves it there.
- R10: Waking from full power-down uses the longer full power-up delay. During that delay the mode stays at full power-down with `powering` high. It becomes normal with `powering` low once the delay has ended.
- R11: `convValid` and `convAbort` are each exactly one system-clock cycle wide, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Raw chip-select, active low, asynchronous |
| sclk | input | 1 | Raw serial clock, asynchronous |
| mode | output | 2 | Current power mode (0 normal, 1 partial, 2 full) |
| convValid | output | 1 | One-cycle pulse: a complete conversion frame ended |
| convAbort | output | 1 | One-cycle pulse: a conversion frame was cut short |
| powering | output | 1 | High while the power-up delay runs |

## Verification
Frames are driven with edge counts on both sides of each threshold: 0, 1, 2, 9, 10, 12, 14 and 16. These show which window the chip-select rise falls into, and that counting past 14 changes nothing. Each count is tried from every mode, because the same count must give a glitch filter, an abort, a deeper power-down or a wake-up depending on the state. Wake-ups are checked before and after the delay runs out. Pulses are counted cycle by cycle, which separates a frame that only wakes the part from the first frame that completes a conversion.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PARTIAL = 2'd1,
    MODE_FULL    = 2'd2
  } pmcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPart;
    logic loadFull;
  } pmcStrobe_t;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5,
  parameter int PU_W        = 8,
  parameter int PU_PART_CYC = 34,
  parameter int PU_FULL_CYC = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  pmcStrobe_t       strobe,
  output logic             csFall,
  output logic             csRise,
  output logic             sclkFallLow,
  output logic [CNT_W-1:0] edgeCnt,
  output logic             puDone,
  output logic             powering
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [PU_W-1:0]  PU_PART  = PU_W'(PU_PART_CYC);
  localparam logic [PU_W-1:0]  PU_FULL  = PU_W'(PU_FULL_CYC);
  localparam logic [PU_W-1:0]  PU_ONE   = PU_W'(1);

  logic csSync, sclkSync, csPrev, sclkPrev;
  logic [PU_W-1:0] puCnt;

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csSync (
    .clk(clk), .rstN(rstN), .d(csN), .q(csSync));

  pmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclkSync (
    .clk(clk), .rstN(rstN), .d(sclk), .q(sclkSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csPrev   <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign csFall      = csPrev & ~csSync;
  assign csRise      = ~csPrev & csSync;
  assign sclkFallLow = sclkPrev & ~sclkSync & ~csSync;

  // falling-edge counter, restarted by every frame start, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               edgeCnt <= '0;
    else if (csFall)                         edgeCnt <= '0;
    else if (sclkFallLow && edgeCnt != CNT_MAX) edgeCnt <= edgeCnt + 1'b1;
  end

  // power-up delay on the system clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 puCnt <= '0;
    else if (strobe.loadFull)  puCnt <= PU_FULL;
    else if (strobe.loadPart)  puCnt <= PU_PART;
    else if (puCnt != '0)      puCnt <= puCnt - 1'b1;
  end

  assign puDone   = (puCnt == PU_ONE);
  assign powering = (puCnt != '0);
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int CNT_W        = 5,
  parameter int GLITCH_EDGES = 2,
  parameter int WAKE_EDGES   = 10,
  parameter int DONE_EDGES   = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csFall,
  input  logic             csRise,
  input  logic             sclkFallLow,
  input  logic [CNT_W-1:0] edgeCnt,
  input  logic             puDone,
  input  logic             powering,
  output pmcStrobe_t       strobe,
  output pmcMode_e         mode,
  output logic             convValid,
  output logic             convAbort
);
  localparam logic [CNT_W-1:0] GLITCH_N = CNT_W'(GLITCH_EDGES);
  localparam logic [CNT_W-1:0] WAKE_N   = CNT_W'(WAKE_EDGES);
  localparam logic [CNT_W-1:0] WAKE_PRE = CNT_W'(WAKE_EDGES - 1);
  localparam logic [CNT_W-1:0] DONE_N   = CNT_W'(DONE_EDGES);

  pmcMode_e modeNxt;
  logic     validNxt, abortNxt, frameOk, wakeHit;

  // a frame counts as a real conversion only if it began fully powered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       frameOk <= 1'b1;
    else if (csFall) frameOk <= (mode == MODE_NORMAL) && !powering;
  end

  // the edge about to become the wake threshold starts a power-up
  assign wakeHit = sclkFallLow && (edgeCnt == WAKE_PRE)
                   && (mode != MODE_NORMAL) && !powering;
  assign strobe.loadPart = wakeHit && (mode == MODE_PARTIAL);
  assign strobe.loadFull = wakeHit && (mode == MODE_FULL);

  always_comb begin
    modeNxt  = mode;
    validNxt = 1'b0;
    abortNxt = 1'b0;
    if (puDone) begin
      modeNxt = MODE_NORMAL;
    end else if (csRise && !powering) begin
      unique case (mode)
        MODE_NORMAL: begin
          if (frameOk) begin
            if (edgeCnt >= DONE_N) begin
              validNxt = 1'b1;
            end else if (edgeCnt >= WAKE_N) begin
              abortNxt = 1'b1;
            end else if (edgeCnt >= GLITCH_N) begin
              modeNxt  = MODE_PARTIAL;
              abortNxt = 1'b1;
            end
          end
        end
        MODE_PARTIAL: begin
          if (edgeCnt >= GLITCH_N && edgeCnt < WAKE_N) modeNxt = MODE_FULL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_NORMAL;
      convValid <= 1'b0;
      convAbort <= 1'b0;
    end else begin
      mode      <= modeNxt;
      convValid <= validNxt;
      convAbort <= abortNxt;
    end
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int CNT_W        = 5,
  parameter int GLITCH_EDGES = 2,
  parameter int WAKE_EDGES   = 10,
  parameter int DONE_EDGES   = 14,
  parameter int PU_PART_CYC  = 34,
  parameter int PU_FULL_CYC  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output logic [1:0] mode,
  output logic       convValid,
  output logic       convAbort,
  output logic       powering
);
  localparam int PU_W = $clog2(PU_FULL_CYC + 1);

  pmcStrobe_t       strobe;
  pmcMode_e         modeQ;
  logic             csFall, csRise, sclkFallLow, puDone;
  logic [CNT_W-1:0] edgeCnt;

  pmc_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .PU_W(PU_W),
    .PU_PART_CYC(PU_PART_CYC), .PU_FULL_CYC(PU_FULL_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .strobe(strobe),
    .csFall(csFall), .csRise(csRise), .sclkFallLow(sclkFallLow),
    .edgeCnt(edgeCnt), .puDone(puDone), .powering(powering)
  );

  pmc_ctrl #(
    .CNT_W(CNT_W), .GLITCH_EDGES(GLITCH_EDGES),
    .WAKE_EDGES(WAKE_EDGES), .DONE_EDGES(DONE_EDGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFallLow(sclkFallLow), .edgeCnt(edgeCnt), .puDone(puDone),
    .powering(powering), .strobe(strobe), .mode(modeQ),
    .convValid(convValid), .convAbort(convAbort)
  );

  assign mode = modeQ;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       convValid,
  input logic       convAbort,
  input logic       powering
);
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd3);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(convValid && convAbort));

  a_r11_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    convValid |=> !convValid);

  a_r11_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |=> !convAbort);

  a_r9_full_from_partial: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1);

  a_r8_wake_via_delay: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && $past(mode) != 2'd0) |-> $past(powering));

  a_r10_delay_ends_normal: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powering) |-> mode == 2'd0);

  a_r6_valid_when_up: assert property (@(posedge clk) disable iff (!rstN)
    convValid |-> (mode == 2'd0 && !powering));
endmodule

bind pmc_top pmc_checker u_chk (
  .clk(clk), .rstN(rstN), .mode(mode),
  .convValid(convValid), .convAbort(convAbort), .powering(powering)
);

// File: tb/sim_pmc_top.sv
module sim_pmc_top;
  localparam int CLK_P     = 10;
  localparam int PU_PART   = 20;
  localparam int PU_FULL   = 100;
  localparam int SCLK_HALF = 4;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1;
  logic [1:0] mode;
  logic convValid, convAbort, powering;

  typedef struct {
    logic [1:0] mode;
    int         nValid;
    int         nAbort;
    logic       busy;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int   nRun = 0, nFail = 0, cntV = 0, cntA = 0;
  bit   finished = 0;
  event chkEv;

  always #(CLK_P/2) clk = ~clk;

  pmc_top #(.PU_PART_CYC(PU_PART), .PU_FULL_CYC(PU_FULL)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mode(mode),
    .convValid(convValid), .convAbort(convAbort), .powering(powering));

  // monitor: accumulate pulse cycles
  always @(negedge clk) begin
    if (convValid) cntV = cntV + 1;
    if (convAbort) cntA = cntA + 1;
  end

  // monitor: compare against scoreboard entries
  always @(chkEv) begin
    exp_t e;
    e = expQ.pop_front();
    nRun++;
    if (mode !== e.mode || cntV != e.nValid || cntA != e.nAbort ||
        powering !== e.busy) begin
      nFail++;
      $display("FAIL %s: mode=%0d valid=%0d abort=%0d busy=%0b expected mode=%0d valid=%0d abort=%0d busy=%0b",
               e.req, mode, cntV, cntA, powering, e.mode, e.nValid, e.nAbort, e.busy);
    end
    cntV = 0;
    cntA = 0;
  end

  task automatic expectNow(input logic [1:0] m, input int v, input int a,
                           input logic b, input string req);
    expQ.push_back('{mode: m, nValid: v, nAbort: a, busy: b, req: req});
    ->chkEv;
    @(negedge clk);
  endtask

  task automatic frame(input int n);
    @(negedge clk);
    csN = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      repeat (SCLK_HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    expectNow(2'd0, 0, 0, 1'b0, "R1 reset state");

    frame(14); expectNow(2'd0, 1, 0, 1'b0, "R6 full frame valid");
    frame(16); expectNow(2'd0, 1, 0, 1'b0, "R2 extra edges still one valid");
    frame(1);  expectNow(2'd0, 0, 0, 1'b0, "R3 one edge glitch");
    frame(0);  expectNow(2'd0, 0, 0, 1'b0, "R3 no edge glitch");
    frame(12); expectNow(2'd0, 0, 1, 1'b0, "R5 cut between 10 and 14");
    frame(10); expectNow(2'd0, 0, 1, 1'b0, "R5 cut at 10");
    frame(5);  expectNow(2'd1, 0, 1, 1'b0, "R4 enter partial");
    frame(1);  expectNow(2'd1, 0, 0, 1'b0, "R7 glitch keeps partial");
    frame(14); expectNow(2'd0, 0, 0, 1'b0, "R8 wake frame not valid");
    frame(14); expectNow(2'd0, 1, 0, 1'b0, "R8 next frame valid");
    frame(2);  expectNow(2'd1, 0, 1, 1'b0, "R4 boundary 2 edges");
    frame(9);  expectNow(2'd2, 0, 0, 1'b0, "R9 partial to full");
    frame(9);  expectNow(2'd2, 0, 0, 1'b0, "R9 full stays on 9");
    frame(1);  expectNow(2'd2, 0, 0, 1'b0, "R9 full stays on 1");
    frame(10); expectNow(2'd2, 0, 0, 1'b1, "R10 long delay running");
    repeat (PU_FULL) @(negedge clk);
    expectNow(2'd0, 0, 0, 1'b0, "R10 awake after long delay");
    frame(14); expectNow(2'd0, 1, 0, 1'b0, "R11 single-cycle valid");
    frame(11); expectNow(2'd0, 0, 1, 1'b0, "R11 single-cycle abort");

    finished = 1;
    summary();
    $finish;
  end
endmodule